// File: doc/BRIEF.md
# AAL1 Header CSI RTS Inserter

This block produces the one-byte AAL1 SAR-PDU header for every cell sent on the virtual circuit that carries the synchronous residual time stamp. A modulo-8 sequence count advances by one for each cell-start strobe. Each new eight-cell cycle begins at count 0, and at that point the block takes one 4-bit residual time stamp (RTS) from an external FIFO and keeps it in a register. The four RTS bits are then placed, MSB first, into the convey-bit (CSI) position of the cells with odd counts. Cells with even counts carry a CSI bit supplied from outside, such as a structured-data pointer flag.

Each header also holds the 3-bit count, a CRC-3 over the 4-bit sequence-number field (CSI plus count), and an even parity bit. The header is registered and shown with a one-cycle valid strobe one clock after the cell-start strobe. If the FIFO is empty when a cycle begins, the previously held RTS is sent again and an underrun indication goes out with that header.

Top module: `aal1_hdr_rts_ins`

## Requirements
- R1: Reset clears the sequence count, so the first header after reset carries count 0. Each cell-start strobe advances the count by one, wrapping from 7 to 0.
- R2: In cells with odd counts, CSI is an RTS bit: count 1 carries RTS bit 3, count 3 bit 2, count 5 bit 1 and count 7 bit 0.
- R3: In cells with even counts, CSI equals the evenCsi input sampled with the cell-start strobe. evenCsi has no effect on the header of an odd-count cell.
- R4: rtsPop is high, combinationally, only in a cycle where cellStart is high, the count to be issued is 0 and rtsEmpty is low. This gives at most one pop per eight-cell cycle.
- R5: The RTS value present on rtsData when it is popped is the one serialised for the whole cycle. Later changes of rtsData have no effect until the next count-0 cell.
- R6: If rtsEmpty is high at a count-0 cell, nothing is popped, the held RTS is reused, and rtsUnderrun is high alongside that header. rtsUnderrun is low alongside every other header. Reset sets the held RTS to 0.
- R7: Header layout: bit 7 CSI, bits 6:4 sequence count, bits 3:1 CRC-3, bit 0 parity.
- R8: The CRC-3 is the remainder of the 4-bit field {CSI, count}, multiplied by x^3, divided by x^3 + x + 1.
- R9: Bit 0 makes the number of ones in the whole 8-bit header even.
- R10: hdrValid is high for exactly the cycle after each cycle in which cellStart is high. With strobes on consecutive cycles it stays high. hdrByte keeps its value between headers. Reset clears hdrValid and hdrByte.
- R11: A reset in the middle of an eight-cell cycle makes the next header carry count 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cellStart | input | 1 | One strobe per transmitted cell |
| rtsData | input | 4 | Head entry of the RTS FIFO |
| rtsEmpty | input | 1 | RTS FIFO has no entry |
| evenCsi | input | 1 | CSI bit for even-count cells |
| rtsPop | output | 1 | Takes the head entry from the RTS FIFO |
| hdrByte | output | 8 | Assembled SAR-PDU header |
| hdrValid | output | 1 | hdrByte is new this cycle |
| rtsUnderrun | output | 1 | The current header's cycle reused a stale RTS |

## Verification
The hardest case to reach is an empty FIFO at exactly a count-0 cell, because that is the only point where the block looks at rtsEmpty. The bench keeps its own FIFO model and feeds it only two entries, so a later cycle starts with an empty FIFO. It then checks that the old RTS bits come out again, that no pop happens, and that the underrun flag appears only with the count-0 header. A second way in is a reset in the middle of a cycle with the FIFO still empty. This shows whether the held RTS was cleared, since the bits sent after the reset would differ if the stale value had survived.

// File: rtl/aal1_hdr_pkg.sv
package aal1_hdr_pkg;
  parameter int SEQ_W = 3;
  parameter int RTS_W = 4;
  parameter int CRC_W = 3;
  parameter logic [CRC_W:0] CRC_POLY = 4'b1011;
  localparam int SN_W = SEQ_W + 1;
  localparam int HDR_W = SN_W + CRC_W + 1;
  localparam int SEL_W = $clog2(RTS_W);

  typedef struct packed {
    logic             issue;
    logic             loadRts;
    logic             markUnderrun;
    logic             useRts;
    logic [SEL_W-1:0] rtsBitSel;
    logic [SEQ_W-1:0] seqVal;
  } ctrlStrobes_t;

  function automatic logic [CRC_W-1:0] snCrc(input logic [SN_W-1:0] sn);
    logic [SN_W+CRC_W-1:0] work;
    work = {sn, {CRC_W{1'b0}}};
    for (int i = SN_W + CRC_W - 1; i >= CRC_W; i--) begin
      if (work[i]) work[i -: CRC_W+1] = work[i -: CRC_W+1] ^ CRC_POLY;
    end
    return work[CRC_W-1:0];
  endfunction
endpackage

// File: rtl/aal1_hdr_ctrl.sv
module aal1_hdr_ctrl
  import aal1_hdr_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cellStart,
  input  logic         rtsEmpty,
  output ctrlStrobes_t strb
);
  logic [SEQ_W-1:0] seqCount;
  logic             frameStart;

  always_ff @(posedge clk) begin
    if (!rstN) seqCount <= '0;
    else if (cellStart) seqCount <= seqCount + 1'b1;
  end

  always_comb begin
    frameStart        = (seqCount == '0);
    strb.issue        = cellStart;
    strb.loadRts      = cellStart && frameStart && !rtsEmpty;
    strb.markUnderrun = cellStart && frameStart && rtsEmpty;
    strb.useRts       = seqCount[0];
    strb.rtsBitSel    = SEL_W'(RTS_W - 1) - seqCount[SEQ_W-1:1];
    strb.seqVal       = seqCount;
  end

  assert_seq_step_R1: assert property (@(posedge clk) disable iff (!rstN)
    cellStart |=> seqCount == SEQ_W'($past(seqCount) + 1'b1));
  assert_seq_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    !cellStart |=> $stable(seqCount));
endmodule

// File: rtl/aal1_hdr_dp.sv
module aal1_hdr_dp
  import aal1_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strb,
  input  logic [RTS_W-1:0] rtsData,
  input  logic             evenCsi,
  output logic [HDR_W-1:0] hdrByte,
  output logic             hdrValid,
  output logic             rtsUnderrun
);
  logic [RTS_W-1:0] rtsHold;
  logic             csiBit;
  logic [SN_W-1:0]  snField;
  logic [HDR_W-2:0] hdrNoPar;
  logic [HDR_W-1:0] nextHdr;

  always_comb begin
    csiBit   = strb.useRts ? rtsHold[strb.rtsBitSel] : evenCsi;
    snField  = {csiBit, strb.seqVal};
    hdrNoPar = {snField, snCrc(snField)};
    nextHdr  = {hdrNoPar, ^hdrNoPar};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rtsHold     <= '0;
      hdrByte     <= '0;
      hdrValid    <= 1'b0;
      rtsUnderrun <= 1'b0;
    end else begin
      hdrValid <= strb.issue;
      if (strb.loadRts) rtsHold <= rtsData;
      if (strb.issue) begin
        hdrByte     <= nextHdr;
        rtsUnderrun <= strb.markUnderrun;
      end
    end
  end

  assert_rts_capture_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadRts |=> rtsHold == $past(rtsData));
  assert_rts_keep_R6: assert property (@(posedge clk) disable iff (!rstN)
    !strb.loadRts |=> $stable(rtsHold));
  assert_even_parity_R9: assert property (@(posedge clk) disable iff (!rstN)
    hdrValid |-> (^hdrByte) == 1'b0);
endmodule

// File: rtl/aal1_hdr_rts_ins.sv
module aal1_hdr_rts_ins
  import aal1_hdr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cellStart,
  input  logic [RTS_W-1:0] rtsData,
  input  logic             rtsEmpty,
  input  logic             evenCsi,
  output logic             rtsPop,
  output logic [HDR_W-1:0] hdrByte,
  output logic             hdrValid,
  output logic             rtsUnderrun
);
  ctrlStrobes_t strb;

  aal1_hdr_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cellStart(cellStart), .rtsEmpty(rtsEmpty), .strb(strb)
  );

  aal1_hdr_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .rtsData(rtsData), .evenCsi(evenCsi),
    .hdrByte(hdrByte), .hdrValid(hdrValid), .rtsUnderrun(rtsUnderrun)
  );

  assign rtsPop = strb.loadRts;

  assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rstN)
    cellStart |=> hdrValid);
  assert_valid_quiet_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cellStart |=> !hdrValid);
  assert_pop_gated_R4: assert property (@(posedge clk) disable iff (!rstN)
    rtsPop |-> cellStart && !rtsEmpty);
endmodule

// File: tb/sim_aal1_hdr_rts_ins.sv
`timescale 1ns/1ps
module sim_aal1_hdr_rts_ins;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cellStart = 1'b0;
  logic [3:0] rtsData;
  logic       rtsEmpty;
  logic       evenCsi = 1'b0;
  logic       rtsPop;
  logic [7:0] hdrByte;
  logic       hdrValid;
  logic       rtsUnderrun;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  aal1_hdr_rts_ins u0 (
    .clk(clk), .rstN(rstN), .cellStart(cellStart), .rtsData(rtsData),
    .rtsEmpty(rtsEmpty), .evenCsi(evenCsi), .rtsPop(rtsPop),
    .hdrByte(hdrByte), .hdrValid(hdrValid), .rtsUnderrun(rtsUnderrun)
  );

  // bench FIFO model
  logic [3:0] fifoMem [8];
  int rdPtr = 0;
  int wrCnt = 0;
  assign rtsData  = fifoMem[rdPtr % 8];
  assign rtsEmpty = (rdPtr >= wrCnt);
  always @(posedge clk) if (rtsPop) rdPtr <= rdPtr + 1;

  // expected-state model
  logic [2:0] expSeq = 3'd0;
  logic [3:0] expRts = 4'd0;
  logic [7:0] expHdr;
  logic       expUnder;
  bit         pending = 0;

  // row: {seq[2:0], evenCsi, expected CSI}
  localparam logic [4:0] VEC [16] = '{
    {3'd0,1'b1,1'b1}, {3'd1,1'b0,1'b1}, {3'd2,1'b0,1'b0}, {3'd3,1'b1,1'b0},
    {3'd4,1'b1,1'b1}, {3'd5,1'b0,1'b1}, {3'd6,1'b0,1'b0}, {3'd7,1'b1,1'b0},
    {3'd0,1'b0,1'b0}, {3'd1,1'b1,1'b0}, {3'd2,1'b1,1'b1}, {3'd3,1'b1,1'b0},
    {3'd4,1'b1,1'b1}, {3'd5,1'b0,1'b1}, {3'd6,1'b0,1'b0}, {3'd7,1'b0,1'b1}
  };

  function automatic logic [7:0] mkHdr(input logic csi, input logic [2:0] sq);
    logic [2:0] crc;
    logic [6:0] top;
    crc = (sq[0] ? 3'b011 : 3'b000) ^ (sq[1] ? 3'b110 : 3'b000) ^
          (sq[2] ? 3'b111 : 3'b000) ^ (csi   ? 3'b101 : 3'b000);
    top = {csi, sq, crc};
    return {top, ($countones(top) % 2) == 1};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic checkPrev();
    check(hdrValid === 1'b1, "R10", "hdrValid after strobe", hdrValid, 1);
    check(hdrByte === expHdr, "R7/R8", "header byte", hdrByte, expHdr);
    check(hdrByte[4:6-2] !== 3'bxxx && (^hdrByte) === 1'b0, "R9", "parity", hdrByte, expHdr);
    check(rtsUnderrun === expUnder, "R6", "underrun flag", rtsUnderrun, expUnder);
  endtask

  task automatic stepCell(input logic ev, input bit hold, input bit ovr,
                          input logic [2:0] ovSeq, input logic ovCsi);
    logic expPop;
    logic csi;
    @(negedge clk);
    if (pending) checkPrev();
    cellStart = 1'b1;
    evenCsi = ev;
    #1;
    expPop = (expSeq == 3'd0) && !rtsEmpty;
    check(rtsPop === expPop, "R4", "rtsPop", rtsPop, expPop);
    if (expPop) expRts = rtsData;
    expUnder = (expSeq == 3'd0) && rtsEmpty;
    csi = expSeq[0] ? expRts[3 - expSeq[2:1]] : ev;
    expHdr = ovr ? mkHdr(ovCsi, ovSeq) : mkHdr(csi, expSeq);
    expSeq = expSeq + 3'd1;
    if (hold) pending = 1;
    else begin
      @(negedge clk);
      cellStart = 1'b0;
      checkPrev();
      pending = 0;
    end
  endtask

  task automatic finishCells();
    @(negedge clk);
    cellStart = 1'b0;
    if (pending) checkPrev();
    pending = 0;
    @(negedge clk);
    check(hdrValid === 1'b0, "R10", "hdrValid drops", hdrValid, 0);
  endtask

  initial begin
    logic [7:0] held;
    fifoMem[0] = 4'hA; fifoMem[1] = 4'h3; fifoMem[2] = 4'hC;
    for (int i = 3; i < 8; i++) fifoMem[i] = 4'h0;
    repeat (3) @(negedge clk);
    check(hdrValid === 1'b0, "R10", "reset hdrValid", hdrValid, 0);
    check(hdrByte === 8'h00, "R10", "reset hdrByte", hdrByte, 0);
    check(rtsUnderrun === 1'b0, "R6", "reset underrun", rtsUnderrun, 0);
    rstN = 1'b1;
    wrCnt = 2;

    // table walk: two full cycles, RTS 0xA then 0x3 (R1 R2 R3 R5)
    for (int r = 0; r < 16; r++) begin
      stepCell(VEC[r][1], 1'b0, 1'b1, VEC[r][4:2], VEC[r][0]);
      repeat (r % 3) @(negedge clk);
      check(hdrByte[6:4] === VEC[r][4:2], "R1", "sequence count", hdrByte[6:4], VEC[r][4:2]);
      check(hdrByte[7] === VEC[r][0], "R2/R3", "CSI bit", hdrByte[7], VEC[r][0]);
    end
    held = hdrByte;
    @(negedge clk);
    check(hdrByte === held, "R10", "header holds when idle", hdrByte, held);

    // empty FIFO at count 0: reuse 0x3, flag underrun (R6)
    for (int k = 0; k < 8; k++) begin
      stepCell(1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
      if (k == 5) check(hdrByte[7] === 1'b1, "R6", "reused RTS bit", hdrByte[7], 1);
    end
    check(rdPtr == 2, "R6", "no pop while empty", rdPtr, 2);

    // back-to-back strobes with new RTS 0xC (R10 R5)
    wrCnt = 3;
    for (int k = 0; k < 8; k++) stepCell(1'b1, 1'b1, 1'b0, 3'd0, 1'b0);
    finishCells();
    check(rdPtr == 3, "R4", "one pop per cycle", rdPtr, 3);

    // mid-cycle reset with FIFO empty (R11, R6 reset value)
    for (int k = 0; k < 3; k++) stepCell(1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1;
    expSeq = 3'd0; expRts = 4'd0;
    check(hdrValid === 1'b0, "R10", "hdrValid after reset", hdrValid, 0);
    stepCell(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    check(hdrByte[6:4] === 3'd0, "R11", "count restarts", hdrByte[6:4], 0);
    stepCell(1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    check(hdrByte[7] === 1'b0, "R6", "held RTS cleared by reset", hdrByte[7], 0);

    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule